// File: doc/BRIEF.md
# Single-Bin Quadrature Correlator

This block measures how strongly a 1-bit delta-sigma input stream lines up with a reference sinusoid of a chosen frequency. A phase accumulator advances by a programmable frequency word on every clock. The top nine bits of the phase address a 512-entry sine/cosine table. For every clock of a run, the bit from the selected input channel either adds the two table values to a pair of signed totals or subtracts them. X holds the cosine correlation and Y holds the sine correlation. The same cosine sample also drives an 8-bit offset-binary output, which feeds an external DAC so that the stimulus and the correlation share one phase.

Software writes one command word together with a frequency word. The command word holds an operation code, an input channel and a run length counted in whole reference cycles. When the run ends, the block raises a one-clock done pulse and copies the final totals into a holding pair. A read returns X and Y together and clears the holding pair. This lets a read made during the next run return complete results, and a dummy read leaves the pair at zero. The phase accumulator has PHASE_W bits, and the frequency word is round(f_signal / f_clock · 2^PHASE_W).

Top module: `quad_corr`

## Requirements
- R1: After reset the block is idle: busy, done and rd_valid are low, dac_out is 8'h80, and the holding pair reads as zero.
- R2: A command is accepted when cmd_valid is high and all three of the following hold. The operation code in cmd_word[31:24] equals 8'h01. The channel field in cmd_word[23:17] is below NUM_CH. The length in cmd_word[16:0] is nonzero. Any other command is ignored: an idle block stays idle, and a running measurement continues unchanged.
- R3: An accepted command resets the phase to 0. After that, the frequency word is added to the PHASE_W-bit phase on every clock of the run, and phase[PHASE_W-1 -: 9] addresses the table.
- R4: Table entry k holds cos = round(127·cos(2πk/512)) and sin = round(127·sin(2πk/512)), each as an 8-bit signed value.
- R5: On every clock of a run, the input bit din[channel] equal to 1 adds cos to X and sin to Y. A bit equal to 0 subtracts cos from X and sin from Y.
- R6: A run of length N includes its sample on the clock where the phase adder produces its N-th carry, and it ends on that clock. The edge that ends the run drops busy and raises done for exactly one clock.
- R7: At the end of a run, the final X and Y are copied into the holding pair. A read made during the next run returns those totals.
- R8: A read request returns the holding pair on rd_x and rd_y, with rd_valid high one clock later. The same edge clears the holding pair.
- R9: X and Y saturate at 2^(ACC_W-1)-1 and -2^(ACC_W-1) and never wrap.
- R10: A command accepted during a run abandons that run. The abandoned run produces no done pulse, and the new run starts from cleared totals.
- R11: During a run, dac_out equals the current cosine sample + 128. While idle, dac_out is 8'h80.
- R12: Only the input channel chosen by the command affects the totals.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_word | input | 32 | Operation code, channel and length |
| cmd_freq | input | PHASE_W | Frequency word, taken when a command is accepted |
| din | input | NUM_CH | Delta-sigma input bits, one per channel |
| rd_req | input | 1 | Read and clear the holding pair |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-clock pulse at the end of a run |
| rd_valid | output | 1 | rd_x and rd_y carry read data |
| rd_x | output | ACC_W | Cosine correlation total |
| rd_y | output | ACC_W | Sine correlation total |
| dac_out | output | 8 | Reference cosine sample in offset binary |

## Verification
The command is accepted on edge E0. The sample that uses phase 0 and the bit driven during the following clock is taken on edge E1, and sample k is taken on edge E(k+1). dac_out therefore shows sample k's cosine during the clock before that edge. done, the new holding pair and the fall of busy all appear directly after the edge of the sample that produced the N-th carry. Read data appears one clock after rd_req. The bench drives each input and checks each output at the falling edge. It steps its own phase model in lockstep, one falling edge per sample, so every expected value is compared in exactly the clock in which it is due.

// File: rtl/quad_corr_pkg.sv
package quad_corr_pkg;
  localparam int CMD_W    = 32;
  localparam int MODE_LSB = 24;
  localparam int CHAN_LSB = 17;
  localparam int LEN_W    = CHAN_LSB;
  localparam int CHF_W    = MODE_LSB - CHAN_LSB;
  localparam int TBL_AW   = 9;
  localparam int SMP_W    = 8;
  localparam int TBL_AMP  = 127;
  localparam logic [7:0] MODE_RUN = 8'h01;
  localparam real TWO_PI  = 6.283185307179586;

  typedef struct packed {
    logic [7:0]       op;
    logic [CHF_W-1:0] chan;
    logic [LEN_W-1:0] len;
  } cmd_t;

  // Rounded table value, half away from zero; evaluated only at elaboration.
  function automatic int wave_entry(input int idx, input bit want_sin);
    real ang;
    real v;
    ang = TWO_PI * real'(idx) / real'(2 ** TBL_AW);
    v   = real'(TBL_AMP) * (want_sin ? $sin(ang) : $cos(ang));
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(0.5 - v);
  endfunction
endpackage

// File: rtl/corr_nco.sv
module corr_nco #(
  parameter int PW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  input  logic [PW-1:0] freq,
  output logic [PW-1:0] phase,
  output logic          wrap
);
  logic [PW:0] sum;

  assign sum  = {1'b0, phase} + {1'b0, freq};
  assign wrap = run & sum[PW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase <= '0;
    else if (clear) phase <= '0;
    else if (run)   phase <= sum[PW-1:0];
  end
endmodule

// File: rtl/corr_wave_rom.sv
module corr_wave_rom #(
  parameter int AW = 9,
  parameter int SW = 8
) (
  input  logic [AW-1:0]        idx,
  output logic signed [SW-1:0] cos_s,
  output logic signed [SW-1:0] sin_s
);
  localparam int DEPTH = 2 ** AW;

  logic signed [SW-1:0] cos_tab [DEPTH];
  logic signed [SW-1:0] sin_tab [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign cos_tab[g] = SW'(quad_corr_pkg::wave_entry(g, 1'b0));
    assign sin_tab[g] = SW'(quad_corr_pkg::wave_entry(g, 1'b1));
  end

  assign cos_s = cos_tab[idx];
  assign sin_s = sin_tab[idx];
endmodule

// File: rtl/corr_accum.sv
module corr_accum #(
  parameter int AW = 32,
  parameter int SW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 en,
  input  logic                 bit_in,
  input  logic signed [SW-1:0] sample,
  output logic signed [AW-1:0] acc_next
);
  localparam logic signed [AW-1:0] ACC_MAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic signed [AW-1:0] ACC_MIN = {1'b1, {(AW-1){1'b0}}};

  logic signed [AW-1:0] acc;

  // One saturating add or subtract step.
  function automatic logic signed [AW-1:0] sat_step(
    input logic signed [AW-1:0] a,
    input logic signed [SW-1:0] s,
    input logic                 add
  );
    logic signed [AW:0] wa;
    logic signed [AW:0] ws;
    logic signed [AW:0] w;
    wa = {a[AW-1], a};
    ws = {{(AW+1-SW){s[SW-1]}}, s};
    w  = add ? wa + ws : wa - ws;
    if (w[AW] != w[AW-1]) return w[AW] ? ACC_MIN : ACC_MAX;
    return w[AW-1:0];
  endfunction

  assign acc_next = sat_step(acc, sample, bit_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (clear) acc <= '0;
    else if (en)    acc <= acc_next;
  end

  // R9: adding a positive value never lowers the total; subtracting never raises it
  a_r9_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clear && (bit_in == !sample[SW-1]) && sample != '0) |=> acc >= $past(acc));
  a_r9_no_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clear && (bit_in == sample[SW-1]) && sample != '0) |=> acc <= $past(acc));
endmodule

// File: rtl/quad_corr.sv
module quad_corr #(
  parameter int PHASE_W = 31,
  parameter int ACC_W   = 32,
  parameter int NUM_CH  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [31:0]               cmd_word,
  input  logic [PHASE_W-1:0]        cmd_freq,
  input  logic [NUM_CH-1:0]         din,
  input  logic                      rd_req,
  output logic                      busy,
  output logic                      done,
  output logic                      rd_valid,
  output logic signed [ACC_W-1:0]   rd_x,
  output logic signed [ACC_W-1:0]   rd_y,
  output logic [7:0]                dac_out
);
  import quad_corr_pkg::*;

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [CHF_W-1:0] NUM_CH_F = CHF_W'(NUM_CH);
  localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);

  cmd_t                 cmd;
  logic                 cmd_accept;
  logic                 run_en;
  logic                 last_cycle;
  logic                 wrap;
  logic                 sel_bit;
  logic [PHASE_W-1:0]   freq_q;
  logic [PHASE_W-1:0]   phase;
  logic [CH_W-1:0]      chan_q;
  logic [LEN_W-1:0]     remain;
  logic signed [ACC_W-1:0] hold_x;
  logic signed [ACC_W-1:0] hold_y;
  logic signed [SMP_W-1:0] lane_smp [2];
  logic signed [ACC_W-1:0] lane_nxt [2];

  assign cmd        = cmd_t'(cmd_word);
  assign cmd_accept = cmd_valid && (cmd.op == MODE_RUN) && (cmd.chan < NUM_CH_F) && (cmd.len != '0);
  assign run_en     = busy && !cmd_accept;
  assign last_cycle = run_en && wrap && (remain == LEN_ONE);
  assign sel_bit    = din[chan_q];

  corr_nco #(.PW(PHASE_W)) u_nco (
    .clk(clk), .rst_n(rst_n), .clear(cmd_accept), .run(run_en),
    .freq(freq_q), .phase(phase), .wrap(wrap)
  );

  corr_wave_rom #(.AW(TBL_AW), .SW(SMP_W)) u_rom (
    .idx(phase[PHASE_W-1 -: TBL_AW]), .cos_s(lane_smp[0]), .sin_s(lane_smp[1])
  );

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    corr_accum #(.AW(ACC_W), .SW(SMP_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clear(cmd_accept), .en(run_en),
      .bit_in(sel_bit), .sample(lane_smp[ln]), .acc_next(lane_nxt[ln])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      freq_q <= '0;
      chan_q <= '0;
      remain <= '0;
    end else begin
      done <= last_cycle;
      if (cmd_accept) begin
        busy   <= 1'b1;
        freq_q <= cmd_freq;
        chan_q <= cmd.chan[CH_W-1:0];
        remain <= cmd.len;
      end else if (last_cycle) begin
        busy   <= 1'b0;
        remain <= '0;
      end else if (run_en && wrap) begin
        remain <= remain - LEN_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_x   <= '0;
      hold_y   <= '0;
      rd_valid <= 1'b0;
      rd_x     <= '0;
      rd_y     <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        rd_x <= hold_x;
        rd_y <= hold_y;
      end
      if (last_cycle) begin
        hold_x <= lane_nxt[0];
        hold_y <= lane_nxt[1];
      end else if (rd_req) begin
        hold_x <= '0;
        hold_y <= '0;
      end
    end
  end

  assign dac_out = busy ? (lane_smp[0] ^ 8'h80) : 8'h80;

  // R6: done marks the end of a run and only that
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r6_fall_done: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  a_r6_remain_live: assert property (@(posedge clk) disable iff (!rst_n) busy |-> remain != '0);
  // R3: every run starts from phase zero
  a_r3_phase_start: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> phase == '0);
  // R2: a rejected command leaves an idle block idle
  a_r2_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && !cmd_accept) |=> !busy);
  // R8: a read leaves the holding pair cleared unless a run ended at the same edge
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !done) |-> (hold_x == '0 && hold_y == '0));
  // R10: a command during a run reloads the length and keeps running
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_accept) |=> (busy && remain == $past(cmd.len)));
endmodule

// File: tb/quad_corr_test.sv
module quad_corr_test;
  localparam int PW  = 31;
  localparam int AW  = 16;
  localparam int NCH = 4;
  localparam longint PMOD = 64'd1 << PW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, cmd_valid = 1'b0, rd_req = 1'b0;
  logic [31:0] cmd_word = '0;
  logic [PW-1:0] cmd_freq = '0;
  logic [NCH-1:0] din = '0;
  logic busy, done, rd_valid;
  logic signed [AW-1:0] rd_x, rd_y;
  logic [7:0] dac_out;

  quad_corr #(.PHASE_W(PW), .ACC_W(AW), .NUM_CH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_freq(cmd_freq), .din(din), .rd_req(rd_req), .busy(busy), .done(done),
    .rd_valid(rd_valid), .rd_x(rd_x), .rd_y(rd_y), .dac_out(dac_out)
  );

  int checks = 0, errors = 0;
  int qx[$], qy[$];
  string qtag[$];
  int hold_x = 0, hold_y = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int tcos(input int k);
    return int'(127.0 * $cos(6.283185307179586 * real'(k) / 512.0));
  endfunction
  function automatic int tsin(input int k);
    return int'(127.0 * $sin(6.283185307179586 * real'(k) / 512.0));
  endfunction

  function automatic int clampv(input longint v);
    longint hi = (64'sd1 <<< (AW-1)) - 1;
    longint lo = -(64'sd1 <<< (AW-1));
    if (v > hi) return int'(hi);
    if (v < lo) return int'(lo);
    return int'(v);
  endfunction

  function automatic logic [31:0] mk_cmd(input int op, input int ch, input int len);
    return {8'(op), 7'(ch), 17'(len)};
  endfunction

  function automatic logic [NCH-1:0] pattern(input int sel, input int k, input int idx);
    logic [NCH-1:0] v;
    for (int c = 0; c < NCH; c++) begin
      case (sel)
        0: v[c] = 1'b1;
        1: v[c] = k[0] ^ c[0];
        2: v[c] = ((k * (3 + 2*c) + c) % 7) < 3;
        3: v[c] = (idx < 256);
        default: v[c] = ((k >> c) & 1) == 1;
      endcase
    end
    return v;
  endfunction

  // Scoreboard monitor: every read result is matched against the queue
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (qx.size() == 0) begin
        check(1'b0, "R8", "read with nothing expected", 1, 0);
      end else begin
        int ex, ey;
        string tg;
        ex = qx.pop_front(); ey = qy.pop_front(); tg = qtag.pop_front();
        check(int'(rd_x) == ex, tg, "X total", rd_x, ex);
        check(int'(rd_y) == ey, tg, "Y total", rd_y, ey);
      end
    end
  end

  // R8: read request pushes the expected holding pair, which then clears
  task automatic do_read(input string tag);
    rd_req = 1'b1;
    qx.push_back(hold_x); qy.push_back(hold_y); qtag.push_back(tag);
    hold_x = 0; hold_y = 0;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  // R2: a rejected command leaves an idle block idle
  task automatic idle_reject(input logic [31:0] w, input string what);
    cmd_valid = 1'b1; cmd_word = w; cmd_freq = PW'(1000);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy == 1'b0, "R2", what, busy, 0);
  endtask

  // One measurement with the phase model stepped per sample (R3, R4, R5, R6, R11)
  task automatic run_meas(input int ch, input int len, input longint fw, input int sel,
                          input int rd_at, input int bad_at, input int bad_kind,
                          input string tag);
    longint p = 0, sx = 0, sy = 0;
    int wraps = 0, k = 0, idx;
    logic [NCH-1:0] dv;
    cmd_valid = 1'b1; cmd_word = mk_cmd(1, ch, len); cmd_freq = PW'(fw);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy == 1'b1, "R2", "run started", busy, 1);
    while (wraps < len) begin
      idx = int'(p >> (PW - 9));
      dv  = pattern(sel, k, idx);
      din = dv;
      check(dac_out == 8'((tcos(idx) + 128) & 255), "R11", "dac sample", dac_out,
            (tcos(idx) + 128) & 255);
      check(done == 1'b0, "R6", "done early", done, 0);
      sx = clampv(dv[ch] ? sx + tcos(idx) : sx - tcos(idx));
      sy = clampv(dv[ch] ? sy + tsin(idx) : sy - tsin(idx));
      if (k == rd_at) begin
        rd_req = 1'b1;
        qx.push_back(hold_x); qy.push_back(hold_y); qtag.push_back("R7");
        hold_x = 0; hold_y = 0;
      end
      if (k == bad_at) begin
        cmd_valid = 1'b1; cmd_freq = PW'(fw + 12345);
        case (bad_kind)
          0: cmd_word = mk_cmd(2, ch, len);
          1: cmd_word = mk_cmd(1, ch, 0);
          default: cmd_word = mk_cmd(1, NCH, len);
        endcase
      end
      p = p + fw;
      if (p >= PMOD) begin p = p - PMOD; wraps++; end
      k++;
      @(negedge clk);
      rd_req = 1'b0; cmd_valid = 1'b0;
    end
    din = '0;
    check(done == 1'b1, "R6", {tag, " done at last carry"}, done, 1);
    check(busy == 1'b0, "R6", {tag, " busy cleared"}, busy, 0);
    hold_x = int'(sx); hold_y = int'(sy);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R6 watchdog: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1", "busy", busy, 0);
    check(done == 1'b0, "R1", "done", done, 0);
    check(rd_valid == 1'b0, "R1", "rd_valid", rd_valid, 0);
    check(dac_out == 8'h80, "R1", "dac idle", dac_out, 128);
    do_read("R1");
    // R2: rejected commands while idle
    idle_reject(mk_cmd(2, 0, 5), "bad opcode ignored");
    idle_reject(mk_cmd(1, 5, 5), "channel out of range ignored");
    idle_reject(mk_cmd(1, 0, 0), "zero length ignored");
    check(dac_out == 8'h80, "R11", "dac idle after rejects", dac_out, 128);
    // R5: all ones on channel 0, integer cycle length
    run_meas(0, 4, PMOD / 16, 0, -1, -1, 0, "R5");
    do_read("R5");
    // R3: frequency word for 1.2 MHz at 200 MHz; R2 reject during a run
    run_meas(1, 12, 64'd12884902, 2, -1, 30, 0, "R3");
    do_read("R3");
    run_meas(1, 3, PMOD / 40, 1, -1, 17, 1, "R2");
    do_read("R2");
    run_meas(2, 2, PMOD / 40, 1, -1, 9, 2, "R2");
    do_read("R2");
    // R12: per-channel distinct patterns; R7 read during the next run
    run_meas(2, 3, PMOD / 50 + 7, 4, -1, -1, 0, "R12");
    run_meas(3, 3, PMOD / 50 + 7, 4, 20, -1, 0, "R12");
    do_read("R12");
    // R10: abandon a run with a new command
    cmd_valid = 1'b1; cmd_word = mk_cmd(1, 0, 50); cmd_freq = PW'(PMOD / 16);
    din = '1;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 20; i++) begin
      check(done == 1'b0 && busy == 1'b1, "R10", "first run still going", done, 0);
      @(negedge clk);
    end
    run_meas(1, 2, PMOD / 16, 1, -1, -1, 0, "R10");
    do_read("R10");
    // R4: input in phase with the sine gives a large Y
    run_meas(0, 5, PMOD / 64, 3, -1, -1, 0, "R4");
    do_read("R4");
    // R9: long slow cycle drives X to the top rail and Y to the bottom rail
    run_meas(0, 1, PMOD / 4096, 0, -1, -1, 0, "R9");
    check(hold_y == -(1 << (AW-1)), "R9", "model reaches lower rail", hold_y, -(1 << (AW-1)));
    do_read("R9");
    repeat (3) @(negedge clk);
    check(qx.size() == 0, "R8", "all reads returned", qx.size(), 0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule